// File: doc/BRIEF.md
# Selectable-Timeout Watchdog Reset Generator

This block watches for a periodic kick from software or a supervising agent. It raises a reset request when the chosen interval passes without a kick. A 2-bit code picks one of three timeout lengths, or switches the timeout source off. The block counts ticks from an external prescaler, so each interval is a number of ticks that is set by a parameter. With the default values and a 1 ms tick, the intervals are about 1.4 s, 600 ms and 200 ms.

An external comparator reports when the supply is low. While that indication is high the reset request is held, and so is the power-up condition. When the supply recovers, and after the power-on reset releases, the request stays active for a fixed number of ticks. A watchdog expiry also produces a request of that same length, and counting then starts again from zero.

The output is the enable of an open-drain pull-down. A 1 pulls the reset line low. A 0 releases it, and the external pull-up then raises it. The block never drives the line high.

Top module: `wdg_reset_gen`

## Requirements
- R1: While `rst_ni` is low, `rst_pull_low_o` is 1. After `rst_ni` rises, it stays 1 for exactly `PULSE_TICKS` cycles in which `tick_i` is high, then goes to 0.
- R2: When `rst_pull_low_o` is 0 and no kick arrives, a timeout sets `rst_pull_low_o` to 1 after a set number of tick cycles. That number is `TMO0_TICKS` for code 2'b00, `TMO1_TICKS` for code 2'b01 and `TMO2_TICKS` for code 2'b10.
- R3: Code 2'b11 disables the timeout. No number of ticks without a kick makes `rst_pull_low_o` go to 1.
- R4: A cycle with `kick_i` high sets the timeout count back to zero.
- R5: A change of `tmo_sel_i` from its value in the previous cycle sets the count back to zero. The new limit then applies from that point.
- R6: A timeout holds `rst_pull_low_o` at 1 for exactly `PULSE_TICKS` ticks. After that the output returns to 0 and the next timeout needs the full limit again.
- R7: `rst_pull_low_o` is 1 in the same cycle that `supply_low_i` is 1, with no register delay. While the supply is low the timeout count stays at zero.
- R8: When `supply_low_i` falls, `rst_pull_low_o` stays 1 for exactly `PULSE_TICKS` further ticks.
- R9: Cycles in which `tick_i` is low do not advance the timeout count or the pulse length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-cycle prescaler strobe that advances the counters |
| kick_i | input | 1 | Restarts the timeout count |
| tmo_sel_i | input | 2 | Timeout code: 00 long, 01 medium, 10 short, 11 off |
| supply_low_i | input | 1 | Supply-below-trip indication from an external comparator |
| rst_pull_low_o | output | 1 | Open-drain enable: 1 pulls the reset line low, 0 releases it |

## Verification
The first directed runs hold the tick high in every cycle and count cycles edge by edge. This shows whether each code reaches its own limit and whether the reset pulse has the exact length. It also shows whether a code change or a kick restarts the count, as opposed to merely holding it. A run with the tick held low for a long stretch separates counting ticks from counting clock cycles. Supply-low pulses, some during a count and some during code 11, show the zero-delay output path and the zeroing of the count. A long stretch of random ticks, kicks, code changes and supply dips is then compared cycle by cycle with a behavioural model.

// File: rtl/wdg_rst_pkg.sv
package wdg_rst_pkg;

    // Timeout selection codes; the position of each code is decoded by wdg_tmo_decode
    typedef enum logic [1:0] {
        TMO_LONG  = 2'b00,
        TMO_MID   = 2'b01,
        TMO_SHORT = 2'b10,
        TMO_OFF   = 2'b11
    } tmo_code_e;

endpackage

// File: rtl/wdg_tmo_decode.sv
module wdg_tmo_decode
    import wdg_rst_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int TMO0_TICKS = 1400,
    parameter int TMO1_TICKS = 600,
    parameter int TMO2_TICKS = 200
) (
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] limit_o,
    output logic             enable_o
);

    always_comb begin
        enable_o = 1'b1;
        limit_o  = '0;
        case (tmo_code_e'(sel_i))
            TMO_LONG:  limit_o = CNT_W'(TMO0_TICKS);
            TMO_MID:   limit_o = CNT_W'(TMO1_TICKS);
            TMO_SHORT: limit_o = CNT_W'(TMO2_TICKS);
            TMO_OFF: begin
                limit_o  = '0;
                enable_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wdg_pulse_timer.sv
module wdg_pulse_timer #(
    parameter int PULSE_TICKS = 150,
    parameter int PW          = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic hold_i,     // supply low: keep active, restart length
    input  logic restart_i,  // watchdog expiry: start a new pulse
    output logic active_o
);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] cnt;
    } pulse_state_t;

    pulse_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hold_i || restart_i) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
        end else if (s_q.active && tick_i) begin
            if (s_q.cnt == PW'(PULSE_TICKS - 1)) begin
                s_d.active = 1'b0;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.active <= 1'b1;
            s_q.cnt    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;

    // R6: the pulse length counter never passes its limit
    a_r6_pulse_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt < PW'(PULSE_TICKS));

    // R8: a low supply restarts the pulse from its beginning
    a_r8_hold_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (active_o && s_q.cnt == '0));

    // R9: with no tick and no restart the pulse state does not move
    a_r9_pulse_waits_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !hold_i && !restart_i) |=> $stable(s_q));

endmodule

// File: rtl/wdg_wd_counter.sv
module wdg_wd_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             run_i,     // counting allowed (no reset request active)
    input  logic             clear_i,   // kick or code change
    input  logic             enable_i,  // timeout source enabled by the code
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wd_state_t;

    wd_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        if (!run_i || clear_i) begin
            s_d.cnt = '0;
        end else if (tick_i && enable_i) begin
            if (s_q.cnt == limit_i - CNT_W'(1)) begin
                expire_o = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: a running count stays below the selected limit
    a_r2_cnt_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && run_i && !clear_i) |-> (s_q.cnt < limit_i));

    // R4/R5: a kick or code change leaves the count at zero
    a_r4_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (s_q.cnt == '0));

    // R7: while counting is blocked the count sits at zero
    a_r7_blocked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (s_q.cnt == '0));

    // R3: a disabled timeout never expires
    a_r3_off_no_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !expire_o);

endmodule

// File: rtl/wdg_reset_gen.sv
module wdg_reset_gen
    import wdg_rst_pkg::*;
#(
    parameter int TMO0_TICKS  = 1400,
    parameter int TMO1_TICKS  = 600,
    parameter int TMO2_TICKS  = 200,
    parameter int PULSE_TICKS = 150
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic [1:0] tmo_sel_i,
    input  logic       supply_low_i,
    output logic       rst_pull_low_o
);

    localparam int MAX01   = (TMO0_TICKS > TMO1_TICKS) ? TMO0_TICKS : TMO1_TICKS;
    localparam int MAX_T   = (MAX01 > TMO2_TICKS) ? MAX01 : TMO2_TICKS;
    localparam int CNT_W   = $clog2(MAX_T + 1);
    localparam int PULSE_W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [1:0] sel;
    } top_state_t;

    top_state_t s_d, s_q;

    logic             sel_change;
    logic             pulse_active;
    logic             expire;
    logic             tmo_enable;
    logic [CNT_W-1:0] tmo_limit;

    always_comb begin
        s_d        = s_q;
        s_d.sel    = tmo_sel_i;
        sel_change = (tmo_sel_i != s_q.sel);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.sel <= TMO_LONG;
        end else begin
            s_q <= s_d;
        end
    end

    wdg_tmo_decode #(
        .CNT_W      (CNT_W),
        .TMO0_TICKS (TMO0_TICKS),
        .TMO1_TICKS (TMO1_TICKS),
        .TMO2_TICKS (TMO2_TICKS)
    ) u_decode (
        .sel_i    (tmo_sel_i),
        .limit_o  (tmo_limit),
        .enable_o (tmo_enable)
    );

    wdg_wd_counter #(
        .CNT_W (CNT_W)
    ) u_wd_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .run_i    (!pulse_active && !supply_low_i),
        .clear_i  (kick_i || sel_change),
        .enable_i (tmo_enable),
        .limit_i  (tmo_limit),
        .expire_o (expire)
    );

    wdg_pulse_timer #(
        .PULSE_TICKS (PULSE_TICKS),
        .PW          (PULSE_W)
    ) u_pulse (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .hold_i    (supply_low_i),
        .restart_i (expire),
        .active_o  (pulse_active)
    );

    // Open-drain enable: the supply path bypasses every register
    assign rst_pull_low_o = pulse_active || supply_low_i;

    // R6: an expiry turns the reset request on in the next cycle
    a_r6_expire_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire |=> rst_pull_low_o);

    // R7: a low supply is seen at the output in the same cycle
    a_r7_supply_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        supply_low_i |-> rst_pull_low_o);

    // R1/R8: the request only releases on a tick cycle
    a_r1_release_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_pull_low_o && !tick_i && !supply_low_i) |=> rst_pull_low_o);

endmodule

// File: tb/wdg_reset_gen_tb.sv
module wdg_reset_gen_tb_top;

    localparam int T0 = 40;
    localparam int T1 = 24;
    localparam int T2 = 12;
    localparam int P  = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       kick;
    logic [1:0] sel;
    logic       low;
    logic       drive;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    string cur_req = "R1";

    // behavioural model state
    int  m_act, m_pc, m_wc, m_sp;

    always #4 clk = ~clk;

    wdg_reset_gen #(
        .TMO0_TICKS  (T0),
        .TMO1_TICKS  (T1),
        .TMO2_TICKS  (T2),
        .PULSE_TICKS (P)
    ) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .tick_i         (tick),
        .kick_i         (kick),
        .tmo_sel_i      (sel),
        .supply_low_i   (low),
        .rst_pull_low_o (drive)
    );

    function automatic int lim_of(int code);
        if (code == 0) return T0;
        if (code == 1) return T1;
        return T2;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // reference model, updated on each clock edge from the applied inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 1; m_pc = 0; m_wc = 0; m_sp = 0;
        end else begin
            bit chg;
            chg  = (int'(sel) != m_sp);
            m_sp = int'(sel);
            if (low) begin
                m_act = 1; m_pc = 0; m_wc = 0;
            end else if (m_act == 1) begin
                m_wc = 0;
                if (tick) begin
                    if (m_pc + 1 >= P) begin m_act = 0; m_pc = 0; end
                    else m_pc++;
                end
            end else if (kick || chg) begin
                m_wc = 0;
            end else if (tick && sel != 2'b11) begin
                if (m_wc + 1 >= lim_of(int'(sel))) begin m_act = 1; m_pc = 0; m_wc = 0; end
                else m_wc++;
            end
        end
    end

    // per-cycle comparison away from the clock edge
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            int exp;
            exp = (m_act == 1 || low) ? 1 : 0;
            check(int'(drive) == exp, cur_req, int'(drive), exp);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // counts negedges until drive reaches the target value
    task automatic meas(input logic target, output int n);
        n = 0;
        do begin
            @(negedge clk);
            #1;
            n++;
        end while (drive !== target && n < 2000);
    endtask

    task automatic quiet(int cycles, string req);
        int highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            #1;
            if (drive) highs++;
        end
        check(highs == 0, req, highs, 0);
    endtask

    initial begin
        int n;
        int order[3] = '{1, 2, 0};
        rst_n = 1'b0; tick = 1'b1; kick = 1'b0; sel = 2'b00; low = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(drive == 1'b1, "R1", int'(drive), 1);
        @(negedge clk);
        rst_n = 1'b1;
        meas(1'b0, n);
        check(n == P, "R1", n, P);

        // R2 and R6: each code, pulse length and restart from zero
        foreach (order[k]) begin
            cur_req = "R2";
            @(negedge clk);
            sel = 2'(order[k]);
            meas(1'b1, n);
            check(n == lim_of(order[k]) + 1, "R2", n, lim_of(order[k]) + 1);
            cur_req = "R6";
            meas(1'b0, n);
            check(n == P, "R6", n, P);
            meas(1'b1, n);
            check(n == lim_of(order[k]), "R6", n, lim_of(order[k]));
            meas(1'b0, n);
            check(n == P, "R6", n, P);
        end

        // R5: code change mid-count restarts with the new limit
        cur_req = "R5";
        repeat (20) @(negedge clk);
        sel = 2'b10;
        meas(1'b1, n);
        check(n == T2 + 1, "R5", n, T2 + 1);
        meas(1'b0, n);

        // R4: regular kicks keep the request off
        cur_req = "R4";
        for (int j = 0; j < 10; j++) begin
            quiet(9, "R4");
            kick = 1'b1;
            @(negedge clk);
            kick = 1'b0;
        end
        meas(1'b1, n);
        check(n == T2, "R4", n, T2);
        meas(1'b0, n);

        // R9: no tick, no progress
        cur_req = "R9";
        @(negedge clk);
        tick = 1'b0;
        quiet(100, "R9");
        tick = 1'b1;
        meas(1'b1, n);
        check(n == T2 - 1, "R9", n, T2 - 1);
        tick = 1'b0;
        repeat (30) @(negedge clk);
        #1;
        check(drive == 1'b1, "R9", int'(drive), 1);
        tick = 1'b1;
        meas(1'b0, n);
        check(n == P, "R9", n, P);

        // R3: disabled timeout
        cur_req = "R3";
        sel = 2'b11;
        quiet(300, "R3");

        // R7 and R8: supply low
        cur_req = "R7";
        @(negedge clk);
        low = 1'b1;
        #1;
        check(drive == 1'b1, "R7", int'(drive), 1);
        sel = 2'b10;
        repeat (5) @(negedge clk);
        low = 1'b0;
        meas(1'b0, n);
        check(n == P, "R8", n, P);
        meas(1'b1, n);
        check(n == T2, "R7", n, T2);
        meas(1'b0, n);
        repeat (8) @(negedge clk);
        low = 1'b1;
        repeat (3) @(negedge clk);
        low = 1'b0;
        meas(1'b0, n);
        check(n == P, "R8", n, P);
        meas(1'b1, n);
        check(n == T2, "R7", n, T2);

        // random traffic against the model
        cur_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            tick = ($urandom_range(0, 1) == 1);
            kick = ($urandom_range(0, 99) < 3);
            if ($urandom_range(0, 199) < 2) sel = 2'($urandom_range(0, 3));
            if (low) low = ($urandom_range(0, 2) != 0);
            else low = ($urandom_range(0, 399) == 0);
        end
        low = 1'b0;
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule